// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact in-order 32-bit processor. Its pipeline has fetch, decode, execute, memory and writeback stages. It runs a five-instruction subset: add immediate, load word, store word, signed set-on-less-than and branch-if-equal. Instruction and data storage are small word arrays inside the core. While the core is held in reset, a loader port fills both arrays. A registered read port then lets the environment inspect data storage after a program has run.

Dependent instructions read each other's results without waiting. In decode, each source operand takes the value of the youngest older instruction still in flight that writes that register. A load is recognised when it is fetched, and the cycle after it is always spent on an inserted bubble, with no fetch. Branches are assumed not taken. A taken branch is resolved in execute, loads the corrected fetch address and clears the two younger pipeline slots to the all-zero no-op word.

A taken branch whose target is its own address ends the program. The core raises a sticky done flag, stops fetching and lets the older instructions drain. Four event counters track resolved branches, taken branches, instruction fetches and data accesses. They can be read at any time.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core clears the fetch address to 0, clears all four counters and `done`, and fills every pipeline slot with the no-op.
- R2: The core uses a 32-bit word with opcode in [31:26], rs in [25:21], rt in [20:16], rd in [15:11], function in [5:0] and a 16-bit signed immediate in [15:0]. Add immediate is opcode 0x08 and writes rs+imm to rt. Set-on-less-than is opcode 0x00 with function 0x2A and writes 1 to rd when rs < rt as signed numbers, otherwise 0. Register 0 always reads as zero, and writes to it are discarded.
- R3: Load word (opcode 0x23, rt <= mem[rs+imm]) is always followed by exactly one bubble cycle in which nothing is fetched. This happens whether or not the next instruction uses the loaded register, and that next instruction still sees the loaded value.
- R4: Decode forwards operands from execute, memory and writeback, and the youngest producer wins. No result destined for register 0 is forwarded.
- R5: Branch-if-equal (opcode 0x04) is predicted not taken. When rs equals rt, fetch restarts at PC+4+(sign-extended imm << 2), and the two younger instructions already fetched are discarded without effect. Store word is opcode 0x2B (mem[rs+imm] <= rt).
- R6: `br_cnt` counts every branch resolved in execute, and `br_miss_cnt` counts the taken ones.
- R7: `imem_cnt` counts every instruction fetch, including wrong-path fetches. `dmem_cnt` counts every load and store that reaches the memory stage.
- R8: A taken branch whose target equals its own address sets `done`. `done` stays set until reset, and no further fetch happens while it is set. Older instructions still complete.
- R9: With `ld_we` high, `ld_wdata` is written at `ld_addr` into instruction storage when `ld_imem` is 1, or into data storage when it is 0. `dm_rdata` shows data word `dm_raddr` one cycle after the address is applied.
- R10: The all-zero word and every unsupported opcode or function code behave as no-ops: no register write, no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write strobe |
| ld_imem | input | 1 | Loader target: 1 instruction array, 0 data array |
| ld_addr | input | max(IMEM_AW, DMEM_AW) | Loader word address |
| ld_wdata | input | 32 | Loader write data |
| dm_raddr | input | DMEM_AW | Inspection word address into data storage |
| dm_rdata | output | 32 | Registered inspection read data |
| done | output | 1 | Sticky halt flag |
| br_cnt | output | CNT_W | Resolved branch count |
| br_miss_cnt | output | CNT_W | Taken (mispredicted) branch count |
| imem_cnt | output | CNT_W | Instruction fetch count |
| dmem_cnt | output | CNT_W | Data access count |

## Verification
Several properties are checked on every cycle: an executing load always has a bubble behind it, a taken branch clears both younger slots and redirects to the computed target, the taken count never passes the branch count, and once halted the core stays halted with the fetch count frozen. Forwarding priority, signed comparison, discarded register-0 writes, suppression of wrong-path stores and the exact counter totals can only be seen by running the bench programs and comparing data storage and counters with values derived by hand.

// File: rtl/mini_core_pkg.sv
package mini_core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_SLT   = 6'h2A;

  typedef enum logic [2:0] {K_NOP, K_ADDI, K_LW, K_SW, K_BEQ, K_SLT} kind_e;

  typedef struct packed {
    kind_e           kind;
    logic            wen;
    logic [4:0]      dst;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] pc;
  } idex_t;

  typedef struct packed {
    kind_e           kind;
    logic            wen;
    logic [4:0]      dst;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] sdata;
  } exmem_t;

  typedef struct packed {
    logic            wen;
    logic [4:0]      dst;
    logic [XLEN-1:0] val;
  } memwb_t;

  function automatic kind_e classify(input logic [31:0] w);
    case (w[31:26])
      OP_ADDI:  return K_ADDI;
      OP_LW:    return K_LW;
      OP_SW:    return K_SW;
      OP_BEQ:   return K_BEQ;
      OP_RTYPE: return (w[5:0] == FN_SLT) ? K_SLT : K_NOP;
      default:  return K_NOP;
    endcase
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  rda,
  output logic [W-1:0]  rdb,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) regs[wa] <= wd;
  end

  assign rda = (ra == '0) ? '0 : regs[ra];
  assign rdb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/mc_fwd.sv
module mc_fwd #(
  parameter int W = 32
) (
  input  logic [4:0]   src,
  input  logic [W-1:0] rf_val,
  input  logic         ex_wen,
  input  logic [4:0]   ex_dst,
  input  logic [W-1:0] ex_val,
  input  logic         mem_wen,
  input  logic [4:0]   mem_dst,
  input  logic [W-1:0] mem_val,
  input  logic         wb_wen,
  input  logic [4:0]   wb_dst,
  input  logic [W-1:0] wb_val,
  output logic [W-1:0] val
);
  always_comb begin
    if (src == 5'd0)                        val = '0;
    else if (ex_wen  && ex_dst  == src)     val = ex_val;
    else if (mem_wen && mem_dst == src)     val = mem_val;
    else if (wb_wen  && wb_dst  == src)     val = wb_val;
    else                                    val = rf_val;
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu import mini_core_pkg::*; #(
  parameter int W = 32
) (
  input  kind_e        kind,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] pc,
  output logic [W-1:0] res,
  output logic         taken,
  output logic [W-1:0] target
);
  always_comb begin
    case (kind)
      K_ADDI, K_LW, K_SW: res = a + imm;
      K_SLT:              res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default:            res = '0;
    endcase
  end

  assign taken  = (kind == K_BEQ) && (a == b);
  assign target = pc + W'(4) + (imm << 2);
endmodule

// File: rtl/mini_core.sv
module mini_core import mini_core_pkg::*; #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int CNT_W   = 32
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         ld_we,
  input  logic                                         ld_imem,
  input  logic [((IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW)-1:0] ld_addr,
  input  logic [XLEN-1:0]                              ld_wdata,
  input  logic [DMEM_AW-1:0]                           dm_raddr,
  output logic [XLEN-1:0]                              dm_rdata,
  output logic                                         done,
  output logic [CNT_W-1:0]                             br_cnt,
  output logic [CNT_W-1:0]                             br_miss_cnt,
  output logic [CNT_W-1:0]                             imem_cnt,
  output logic [CNT_W-1:0]                             dmem_cnt
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IDEPTH];
  logic [XLEN-1:0] dmem [DDEPTH];

  logic [XLEN-1:0] pc, ifid_w, ifid_pc;
  logic            hold;
  idex_t           idex, id_next;
  exmem_t          exmem;
  memwb_t          memwb;

  // ---------------- fetch with load pre-decode ----------------
  logic            fetch_en, fetch_is_lw;
  logic [XLEN-1:0] fetch_w;
  assign fetch_en    = !hold && !done;
  assign fetch_w     = imem[pc[IMEM_AW+1:2]];
  assign fetch_is_lw = (fetch_w[31:26] == OP_LW);

  always_ff @(posedge clk) begin
    if (ld_we && ld_imem) imem[ld_addr[IMEM_AW-1:0]] <= ld_wdata;
  end

  // ---------------- decode with forwarding ----------------
  kind_e           id_kind;
  logic [4:0]      src [2];
  logic [XLEN-1:0] rfv [2];
  logic [XLEN-1:0] opv [2];
  logic [4:0]      id_dst;

  assign id_kind = classify(ifid_w);
  assign src[0]  = ifid_w[25:21];
  assign src[1]  = ifid_w[20:16];
  assign id_dst  = (id_kind == K_SLT) ? ifid_w[15:11] : ifid_w[20:16];

  mc_regfile #(.NREG(32), .W(XLEN)) u_rf (
    .clk(clk), .ra(src[0]), .rb(src[1]), .rda(rfv[0]), .rdb(rfv[1]),
    .we(memwb.wen), .wa(memwb.dst), .wd(memwb.val)
  );

  logic [XLEN-1:0] alu_res, br_target, mem_val;
  logic            br_taken, ex_fwd_wen;
  assign ex_fwd_wen = idex.wen && (idex.kind != K_LW);

  genvar gi;
  for (gi = 0; gi < 2; gi++) begin : g_opnd
    mc_fwd #(.W(XLEN)) u_fwd (
      .src(src[gi]), .rf_val(rfv[gi]),
      .ex_wen(ex_fwd_wen), .ex_dst(idex.dst), .ex_val(alu_res),
      .mem_wen(exmem.wen), .mem_dst(exmem.dst), .mem_val(mem_val),
      .wb_wen(memwb.wen), .wb_dst(memwb.dst), .wb_val(memwb.val),
      .val(opv[gi])
    );
  end

  always_comb begin
    id_next      = '0;
    id_next.kind = id_kind;
    id_next.wen  = (id_kind inside {K_ADDI, K_LW, K_SLT}) && (id_dst != 5'd0);
    id_next.dst  = id_dst;
    id_next.a    = opv[0];
    id_next.b    = opv[1];
    id_next.imm  = {{(XLEN-16){ifid_w[15]}}, ifid_w[15:0]};
    id_next.pc   = ifid_pc;
  end

  // ---------------- execute ----------------
  mc_alu #(.W(XLEN)) u_alu (
    .kind(idex.kind), .a(idex.a), .b(idex.b), .imm(idex.imm), .pc(idex.pc),
    .res(alu_res), .taken(br_taken), .target(br_target)
  );

  // ---------------- memory ----------------
  assign mem_val = (exmem.kind == K_LW) ? dmem[exmem.res[DMEM_AW+1:2]] : exmem.res;

  always_ff @(posedge clk) begin
    if (ld_we && !ld_imem)      dmem[ld_addr[DMEM_AW-1:0]] <= ld_wdata;
    else if (exmem.kind == K_SW) dmem[exmem.res[DMEM_AW+1:2]] <= exmem.sdata;
  end

  always_ff @(posedge clk) dm_rdata <= dmem[dm_raddr];

  // ---------------- pipeline advance ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pc          <= '0;
      hold        <= 1'b0;
      ifid_w      <= '0;
      ifid_pc     <= '0;
      idex        <= '0;
      exmem       <= '0;
      memwb       <= '0;
      done        <= 1'b0;
      br_cnt      <= '0;
      br_miss_cnt <= '0;
      imem_cnt    <= '0;
      dmem_cnt    <= '0;
    end else begin
      exmem <= '{kind: idex.kind, wen: idex.wen, dst: idex.dst, res: alu_res, sdata: idex.b};
      memwb <= '{wen: exmem.wen, dst: exmem.dst, val: mem_val};
      if (br_taken) begin
        pc      <= br_target;
        ifid_w  <= '0;
        ifid_pc <= '0;
        idex    <= '0;
        hold    <= 1'b0;
        if (br_target == idex.pc) done <= 1'b1;
      end else begin
        idex <= id_next;
        if (fetch_en) begin
          ifid_w  <= fetch_w;
          ifid_pc <= pc;
          pc      <= pc + XLEN'(4);
          hold    <= fetch_is_lw;
        end else begin
          ifid_w  <= '0;
          hold    <= 1'b0;
        end
      end
      if (fetch_en)                         imem_cnt    <= imem_cnt + CNT_W'(1);
      if (idex.kind == K_BEQ)               br_cnt      <= br_cnt + CNT_W'(1);
      if (br_taken)                         br_miss_cnt <= br_miss_cnt + CNT_W'(1);
      if (exmem.kind inside {K_LW, K_SW})   dmem_cnt    <= dmem_cnt + CNT_W'(1);
    end
  end

  logic unused_bits;
  assign unused_bits = ^{pc[1:0], pc[XLEN-1:IMEM_AW+2], exmem.res[1:0],
                         exmem.res[XLEN-1:DMEM_AW+2], ifid_w[10:6]};

  // ---------------- assertions ----------------
  AST_LOAD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (idex.kind == K_LW) |-> (ifid_w == '0)); // R3
  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (ifid_w == '0 && idex.kind == K_NOP)); // R5
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst)
    br_taken |=> (pc == $past(idex.pc) + XLEN'(4) + ($past(idex.imm) << 2))); // R5
  AST_MISS_BOUND: assert property (@(posedge clk) disable iff (rst)
    br_miss_cnt <= br_cnt); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8
  AST_HALT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(imem_cnt)); // R8
endmodule

// File: tb/mini_core_tb.sv
module mini_core_tb;
  localparam int CW = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0, ld_imem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_wdata = '0;
  logic [5:0]  dm_raddr = '0;
  logic [31:0] dm_rdata;
  logic        done;
  logic [CW-1:0] br_cnt, br_miss_cnt, imem_cnt, dmem_cnt;

  always #5 clk = ~clk;

  mini_core #(.IMEM_AW(6), .DMEM_AW(6), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_imem(ld_imem), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .dm_raddr(dm_raddr), .dm_rdata(dm_rdata), .done(done),
    .br_cnt(br_cnt), .br_miss_cnt(br_miss_cnt), .imem_cnt(imem_cnt), .dmem_cnt(dmem_cnt)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] slt(input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h2A};
  endfunction

  task automatic load(input logic to_imem, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_imem = to_imem; ld_addr = 6'(a); ld_wdata = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic peek(input int a, output logic [31:0] d);
    @(negedge clk);
    dm_raddr = 6'(a);
    @(negedge clk);
    d = dm_rdata;
  endtask

  task automatic run_to_done();
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R8: actual=not halted expected=halted");
    end
    repeat (6) @(negedge clk);
  endtask

  // {req, addr, value}: expected data words after the main program
  localparam logic [47:0] DM_EXP [14] = '{
    {8'd4,  8'd0,  32'd8},          // R4 EX forward
    {8'd3,  8'd1,  32'd9},          // R3 load-use after bubble
    {8'd2,  8'd2,  32'd0},          // R2 register 0 write discarded
    {8'd5,  8'd3,  32'h0000_1111},  // R5 flushed store
    {8'd5,  8'd4,  32'h0000_2222},  // R5 flushed store
    {8'd4,  8'd5,  32'hFFFF_FFFB},  // R4 MEM forward, negative imm
    {8'd2,  8'd6,  32'd1},          // R2 signed slt true
    {8'd2,  8'd7,  32'd0},          // R2 signed slt false
    {8'd3,  8'd8,  32'd8},          // R3 independent load
    {8'd3,  8'd9,  32'd7},          // R3 instruction after bubble
    {8'd4,  8'd10, 32'd3},          // R4 youngest (EX) wins
    {8'd4,  8'd11, 32'd2},          // R4 MEM over WB
    {8'd8,  8'd12, 32'd0},          // R8 stores past halt flushed
    {8'd10, 8'd13, 32'd5}           // R10 unknown opcode no effect
  };

  initial begin
    logic [31:0] prog [40];
    logic [31:0] d;
    logic [CW-1:0] snap;

    foreach (prog[i]) prog[i] = 32'h0;
    prog[0]  = itype(6'h08, 0, 1, 5);
    prog[1]  = itype(6'h08, 1, 2, 3);
    prog[2]  = itype(6'h08, 1, 3, -10);
    prog[3]  = slt(4, 3, 1);
    prog[4]  = slt(5, 1, 3);
    prog[5]  = itype(6'h2B, 0, 2, 0);
    prog[6]  = itype(6'h23, 0, 6, 0);
    prog[7]  = itype(6'h08, 6, 7, 1);
    prog[8]  = itype(6'h2B, 0, 7, 4);
    prog[9]  = itype(6'h23, 0, 8, 0);
    prog[10] = itype(6'h08, 0, 9, 7);
    prog[11] = itype(6'h04, 1, 2, 5);
    prog[12] = itype(6'h08, 0, 0, 9);
    prog[13] = itype(6'h2B, 0, 0, 8);
    prog[14] = itype(6'h04, 9, 9, 2);
    prog[15] = itype(6'h2B, 0, 1, 12);
    prog[16] = itype(6'h2B, 0, 1, 16);
    prog[18] = itype(6'h08, 0, 12, 1);
    prog[19] = itype(6'h08, 0, 12, 2);
    prog[20] = itype(6'h08, 0, 12, 3);
    prog[21] = itype(6'h08, 12, 13, 0);
    prog[22] = itype(6'h08, 0, 14, 1);
    prog[23] = itype(6'h08, 0, 14, 2);
    prog[24] = {6'h3F, 5'd0, 5'd1, 16'd99};
    prog[25] = itype(6'h08, 14, 15, 0);
    prog[26] = itype(6'h2B, 0, 3, 20);
    prog[27] = itype(6'h2B, 0, 4, 24);
    prog[28] = itype(6'h2B, 0, 5, 28);
    prog[29] = itype(6'h2B, 0, 8, 32);
    prog[30] = itype(6'h2B, 0, 9, 36);
    prog[31] = itype(6'h2B, 0, 13, 40);
    prog[32] = itype(6'h2B, 0, 15, 44);
    prog[33] = itype(6'h2B, 0, 1, 52);
    prog[34] = itype(6'h04, 0, 0, -1);
    prog[35] = itype(6'h2B, 0, 1, 48);
    prog[36] = itype(6'h2B, 0, 1, 48);

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 br_cnt", br_cnt, 32'd0);
    check("R1 br_miss_cnt", br_miss_cnt, 32'd0);
    check("R1 imem_cnt", imem_cnt, 32'd0);
    check("R1 dmem_cnt", dmem_cnt, 32'd0);

    for (int i = 0; i < 40; i++) load(1'b1, i, prog[i]);
    for (int i = 0; i < 16; i++) load(1'b0, i, 32'h0);
    load(1'b0, 2, 32'h0000_DEAD);
    load(1'b0, 3, 32'h0000_1111);
    load(1'b0, 4, 32'h0000_2222);
    peek(3, d);
    check("R9 loader readback", d, 32'h0000_1111);

    @(negedge clk) rst = 1'b0;
    run_to_done();

    foreach (DM_EXP[i]) begin
      peek(int'(DM_EXP[i][39:32]), d);
      check($sformatf("R%0d dmem[%0d]", DM_EXP[i][47:40], DM_EXP[i][39:32]), d, DM_EXP[i][31:0]);
    end

    check("R6 br_cnt", br_cnt, 32'd3);
    check("R6 br_miss_cnt", br_miss_cnt, 32'd2);
    check("R7 imem_cnt", imem_cnt, 32'd37);
    check("R7 dmem_cnt", dmem_cnt, 32'd13);
    check("R8 done", {31'd0, done}, 32'd1);
    snap = imem_cnt;
    repeat (5) @(negedge clk);
    check("R8 no fetch after halt", imem_cnt, snap);

    // R1: reset again clears state
    rst = 1'b1;
    @(negedge clk);
    check("R1 done cleared", {31'd0, done}, 32'd0);
    check("R1 imem_cnt cleared", imem_cnt, 32'd0);

    // R8 boundary: halt as the very first instruction
    load(1'b1, 0, itype(6'h04, 0, 0, -1));
    @(negedge clk) rst = 1'b0;
    run_to_done();
    check("R8 halt at 0 done", {31'd0, done}, 32'd1);
    check("R6 halt at 0 br_cnt", br_cnt, 32'd1);
    check("R6 halt at 0 br_miss_cnt", br_miss_cnt, 32'd1);
    check("R7 halt at 0 imem_cnt", imem_cnt, 32'd3);
    check("R7 halt at 0 dmem_cnt", dmem_cnt, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule